// File: doc/BRIEF.md
# Single-Wire Master Bit-Frame Engine

This block is the master side of a single open-drain wire that carries both data and framing without a separate clock. Each command from the host asks for one frame: send a 0, send a 1, read one bit, or hold the wire released for a start/stop gap. Every data frame opens with the master pulling the wire low. The length of that low pulse encodes the value, a long pulse for 0 and a short one for 1, and the wire is released for the rest of a fixed-length frame. An acknowledge travels as a 0 frame and a negative acknowledge as a 1 frame, so a higher layer issues them as ordinary write or read commands.

For a read, the master issues a brief low pulse and releases the wire. It then samples the wire at a fixed offset into the frame, where a low level means the far end returned 0. A start or stop condition is the wire left released for the hold time. All durations are cycle counts held in two parameter sets, one for fast mode and one for slow mode. A mode input picks the set, and the block captures it when it accepts the command.

A sequence that pauses may resume only while the idle gap stays under the maximum bit period. An idle timer raises a flag when that gap is exceeded, which tells the layer above that it must restart the sequence.

Top module: `sw_bit_master`

## Requirements
- R1: After reset the wire is released (`line_drive_low`=0), `cmd_ready`=1, `rsp_valid`=0 and `idle_timeout`=0.
- R2: Command code 0 (send 0) drives the wire low for the first LOW0 cycles of the frame, and the frame lasts BIT cycles, counted from the cycle after acceptance.
- R3: Command code 1 (send 1) drives the wire low for the first LOW1 cycles of a BIT-cycle frame.
- R4: Command code 2 (read) drives the wire low for the first RDLOW cycles of a BIT-cycle frame and samples `line_in` in frame cycle SAMP. In the cycle `cmd_ready` returns high, `rsp_valid` is 1 for exactly one cycle and `rsp_bit` equals the sampled level, where low reads as 0.
- R5: Command code 3 (start/stop) keeps the wire released for a frame of HTSS cycles while `cmd_ready` stays low.
- R6: `cmd_ready` falls on the cycle after a command is accepted and stays low until the frame ends. A `cmd_valid` raised while `cmd_ready` is low has no effect. The wire is never driven low while `cmd_ready` is high.
- R7: `hs_mode`=1 selects the fast timing set and 0 the slow set. The value present at acceptance governs the whole frame, and a change during the frame has no effect.
- R8: Once a frame has completed, `idle_timeout` rises after IDLE consecutive cycles with no accepted command, where IDLE is the limit of the last frame's mode. It clears on the cycle after the next acceptance, and it never rises before the first frame after reset.
- R9: `rsp_valid` stays 0 for send and start/stop frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_mode | input | 1 | 1 = fast timing set, 0 = slow set |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 send 0, 1 send 1, 2 read, 3 start/stop |
| cmd_ready | output | 1 | Engine idle and able to accept |
| rsp_valid | output | 1 | One-cycle pulse carrying a read result |
| rsp_bit | output | 1 | Sampled read value |
| line_in | input | 1 | Observed wire level |
| line_drive_low | output | 1 | 1 = pull the wire low |
| idle_timeout | output | 1 | Gap between commands exceeded the maximum bit period |

## Verification
The assertions assume the host follows the handshake, so a command counts as issued only on a cycle where `cmd_valid` and `cmd_ready` are both high. They also assume every low time is at least one cycle and shorter than its frame, which makes each low pulse begin on the cycle right after acceptance. The bench keeps within these limits by changing inputs only on the falling clock edge and using the default timing parameters. It models the far end as a pull-down that it asserts only during read frames, and it makes its illegal requests during busy frames only, where the design must ignore them.

// File: rtl/sw_bit_master.sv
module sw_bit_master #(
  parameter int HS_BIT   = 20,
  parameter int HS_LOW0  = 12,
  parameter int HS_LOW1  = 3,
  parameter int HS_RDLOW = 2,
  parameter int HS_SAMP  = 5,
  parameter int HS_HTSS  = 30,
  parameter int HS_IDLE  = 60,
  parameter int LS_BIT   = 40,
  parameter int LS_LOW0  = 24,
  parameter int LS_LOW1  = 6,
  parameter int LS_RDLOW = 4,
  parameter int LS_SAMP  = 10,
  parameter int LS_HTSS  = 50,
  parameter int LS_IDLE  = 120
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs_mode,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output logic       cmd_ready,
  output logic       rsp_valid,
  output logic       rsp_bit,
  input  logic       line_in,
  output logic       line_drive_low,
  output logic       idle_timeout
);
  localparam int CW = $clog2(HS_BIT + HS_HTSS + HS_IDLE + LS_BIT + LS_HTSS + LS_IDLE + 1);
  localparam logic [1:0] OP_W0 = 2'd0, OP_W1 = 2'd1, OP_RD = 2'd2, OP_SS = 2'd3;

  logic          busy, mode_q, rbit_q, rsp_q, armed, to_q;
  logic [1:0]    op_q;
  logic [CW-1:0] cnt, idle_cnt;
  logic [CW-1:0] frame_len, low_len, samp_pt, idle_lim;

  wire accept = cmd_valid && !busy;
  wire frame_end = busy && (cnt == frame_len - CW'(1));

  always_comb begin
    samp_pt  = mode_q ? CW'(HS_SAMP) : CW'(LS_SAMP);
    idle_lim = mode_q ? CW'(HS_IDLE) : CW'(LS_IDLE);
    frame_len = (op_q == OP_SS) ? (mode_q ? CW'(HS_HTSS) : CW'(LS_HTSS))
                                : (mode_q ? CW'(HS_BIT)  : CW'(LS_BIT));
    unique case (op_q)
      OP_W0:   low_len = mode_q ? CW'(HS_LOW0)  : CW'(LS_LOW0);
      OP_W1:   low_len = mode_q ? CW'(HS_LOW1)  : CW'(LS_LOW1);
      OP_RD:   low_len = mode_q ? CW'(HS_RDLOW) : CW'(LS_RDLOW);
      default: low_len = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      mode_q <= 1'b1;
      op_q   <= OP_SS;
      cnt    <= '0;
      rbit_q <= 1'b1;
      rsp_q  <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        mode_q <= hs_mode;
        op_q   <= cmd_op;
        cnt    <= '0;
      end else if (busy) begin
        if (op_q == OP_RD && cnt == samp_pt) rbit_q <= line_in;
        if (frame_end) begin
          busy  <= 1'b0;
          rsp_q <= (op_q == OP_RD);
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      to_q     <= 1'b0;
      idle_cnt <= '0;
    end else if (accept) begin
      armed <= 1'b0;
      to_q  <= 1'b0;
    end else if (frame_end) begin
      armed    <= 1'b1;
      idle_cnt <= '0;
    end else if (!busy && armed && !to_q) begin
      if (idle_cnt == idle_lim - CW'(1)) to_q <= 1'b1;
      else idle_cnt <= idle_cnt + CW'(1);
    end
  end

  assign cmd_ready      = !busy;
  assign rsp_valid      = rsp_q;
  assign rsp_bit        = rbit_q;
  assign idle_timeout   = to_q;
  assign line_drive_low = busy && (cnt < low_len);
endmodule

// File: rtl/sw_bit_master_chk.sv
module sw_bit_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic rsp_valid,
  input logic line_drive_low,
  input logic idle_timeout
);
  AST_READY_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);                           // R6
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !line_drive_low);                                   // R6
  AST_LOW_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_drive_low) |-> $past(cmd_valid && cmd_ready));         // R2
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);                                        // R4
  AST_RSP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> cmd_ready);                                         // R4
  AST_TIMEOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !idle_timeout);                        // R8
  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    idle_timeout |-> cmd_ready);                                      // R8
endmodule

bind sw_bit_master sw_bit_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .line_drive_low(line_drive_low), .idle_timeout(idle_timeout)
);

// File: tb/sim_sw_bit_master.sv
module sim_sw_bit_master;
  logic clk = 0, rst_n = 0, hs_mode = 1, cmd_valid = 0, slave_low = 0;
  logic [1:0] cmd_op = 0;
  logic cmd_ready, rsp_valid, rsp_bit, line_drive_low, idle_timeout;
  wire line_in = !(line_drive_low || slave_low);
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sw_bit_master u0 (.clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_bit(rsp_bit),
    .line_in(line_in), .line_drive_low(line_drive_low), .idle_timeout(idle_timeout));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [1:0] op, input bit hs, input bit slow,
                           input int elow, input int elen, input int ebit,
                           input bit flip, input bit poke, input string req);
    int lows = 0, n = 0, early = 0;
    @(negedge clk); hs_mode = hs; cmd_op = op; cmd_valid = 1; slave_low = slow;
    @(negedge clk); cmd_valid = 0;
    while (!cmd_ready && n < 1000) begin
      if (line_drive_low) lows++;
      if (rsp_valid) early++;
      n++;
      if (flip && n == 1) hs_mode = !hs;
      if (poke && n == 2) begin cmd_valid = 1; cmd_op = 2'd0; end
      if (poke && n == 3) cmd_valid = 0;
      @(negedge clk);
    end
    slave_low = 0; hs_mode = hs;
    check({req, " low cycles"}, lows, elow);
    check({req, " frame cycles"}, n, elen);
    check({req, " no early rsp"}, early, 0);
    check({req, " rsp_valid (R9 for non-read)"}, rsp_valid, op == 2'd2);
    if (op == 2'd2) check({req, " rsp_bit"}, rsp_bit, ebit);
    @(negedge clk);
    check({req, " R6 stays idle after frame"}, cmd_ready && !line_drive_low && !rsp_valid, 1);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 drive", line_drive_low, 0);
    check("R1 ready", cmd_ready, 1);
    check("R1 rsp", rsp_valid, 0);
    check("R1 timeout", idle_timeout, 0);
    rst_n = 1;
    repeat (200) @(negedge clk);
    check("R8 no timeout before first frame", idle_timeout, 0);
  endtask

  task automatic t_writes;
    run_frame(2'd0, 1, 0, 12, 20, 0, 0, 0, "R2 send0 fast");
    run_frame(2'd1, 1, 0, 3, 20, 0, 0, 0, "R3 send1 fast");
    run_frame(2'd0, 0, 0, 24, 40, 0, 0, 0, "R2 R7 send0 slow");
    run_frame(2'd1, 0, 0, 6, 40, 0, 0, 0, "R3 R7 send1 slow");
  endtask

  task automatic t_reads;
    run_frame(2'd2, 1, 1, 2, 20, 0, 0, 0, "R4 read0 fast");
    run_frame(2'd2, 1, 0, 2, 20, 1, 0, 0, "R4 read1 fast");
    run_frame(2'd2, 0, 1, 4, 40, 0, 0, 0, "R4 R7 read0 slow");
    run_frame(2'd2, 0, 0, 4, 40, 1, 0, 0, "R4 R7 read1 slow");
  endtask

  task automatic t_startstop;
    run_frame(2'd3, 1, 0, 0, 30, 0, 0, 0, "R5 startstop fast");
    run_frame(2'd3, 0, 0, 0, 50, 0, 0, 0, "R5 R7 startstop slow");
  endtask

  task automatic t_busy_and_mode;
    run_frame(2'd1, 1, 0, 3, 20, 0, 0, 1, "R6 busy request ignored");
    run_frame(2'd1, 1, 0, 3, 20, 0, 1, 0, "R7 mode flip mid-frame fast");
    run_frame(2'd0, 0, 0, 24, 40, 0, 1, 0, "R7 mode flip mid-frame slow");
  endtask

  task automatic t_timeout;
    int n;
    run_frame(2'd1, 1, 0, 3, 20, 0, 0, 0, "R8 setup fast");
    n = 1;
    while (!idle_timeout && n < 1000) begin @(negedge clk); n++; end
    check("R8 fast timeout delay", n, 60);
    run_frame(2'd1, 0, 0, 6, 40, 0, 0, 0, "R8 setup slow");
    n = 1;
    while (!idle_timeout && n < 1000) begin @(negedge clk); n++; end
    check("R8 slow timeout delay", n, 120);
    @(negedge clk); cmd_op = 2'd3; cmd_valid = 1; hs_mode = 1;
    @(negedge clk); cmd_valid = 0;
    check("R8 timeout cleared by accept", idle_timeout, 0);
    while (!cmd_ready) @(negedge clk);
    repeat (57) @(negedge clk);
    check("R8 short gap no timeout", idle_timeout, 0);
    run_frame(2'd0, 1, 0, 12, 20, 0, 0, 0, "R8 resume after short gap");
    check("R8 still clear", idle_timeout, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk); cyc++;
      if (cyc > 50000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<50000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_writes();
    t_reads();
    t_startstop();
    t_busy_and_mode();
    t_timeout();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule